// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Error Integrator

This block compares a reference clock level against a divided feedback clock level, both sampled by a much faster system clock. Each input passes through a two-flop synchronizer, and a rising edge is found by comparing the newest synchronized sample with the one before it. A tristate detector then drives an UP output after a reference edge and a DN output after a feedback edge. When both would be high, it clears both. The width of each pulse, counted in system clock cycles, follows the phase lead of the input that fired first.

A signed, saturating accumulator integrates UP minus DN once per system clock cycle. It takes the place of a charge pump feeding an integrating loop filter, and it gives the surrounding loop a pole at zero. When the two inputs differ in frequency, pulses of one polarity keep coming and the count drifts steadily in that direction. A slip flag marks each reference edge that arrives while UP is still waiting for its feedback edge. A synchronous clear input zeroes the accumulator.

Top module: `pfd_track`

## Requirements
- R1: A rising edge on `ref_i` sets `up_o` on the third rising clock edge after the new level is first sampled (two synchronizer stages plus the detector register). A falling edge has no effect.
- R2: A rising edge on `fb_i` sets `dn_o` with the same latency as R1. A falling edge has no effect.
- R3: `up_o` and `dn_o` are never high together. Rising edges on both inputs that are detected in the same cycle leave both outputs low. A rising edge on one input while the other output is high clears that other output.
- R4: When `ref_i` rises k cycles before `fb_i`, `up_o` stays high for exactly k cycles and `dn_o` does not pulse. The mirror case holds for a feedback lead.
- R5: When the reference edges come more often than the feedback edges, the accumulator ends positive. In the opposite case it ends negative.
- R6: On each clock edge the accumulator adds 1 if `up_o` alone is high, subtracts 1 if `dn_o` alone is high, and otherwise holds its value.
- R7: The accumulator saturates at the two's-complement limits, +127 and -128 for the default 8-bit width, and never wraps.
- R8: `slip_o` is high for one cycle, registered with the detector state, when a reference edge is detected while `up_o` is high and no feedback edge is detected in the same cycle. `up_o` stays high after a slip.
- R9: `clr_i` high at a clock edge sets the accumulator to 0. This takes priority over any step in that cycle.
- R10: While `rst_ni` is low, `up_o`, `dn_o`, `slip_o` and the accumulator are all 0.
- R11: A level held high on either input creates only one edge, so a long steady high produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference clock level, asynchronous to clk_i |
| fb_i | input | 1 | Divided feedback clock level, asynchronous to clk_i |
| clr_i | input | 1 | Synchronous accumulator clear |
| up_o | output | 1 | Reference-leads pulse |
| dn_o | output | 1 | Feedback-leads pulse |
| err_o | output | ERR_W (8) | Signed integrated phase error |
| slip_o | output | 1 | One-cycle cycle-slip flag |

## Verification
Two pairs of functions can act in the same cycle. The first is an accumulator step and a clear: the bench asserts `clr_i` while `up_o` is high and expects the count to read 0 on the next cycle, not 1. The second is a repeated reference edge and a feedback edge: the bench moves both inputs high in the same cycle while UP is already set, and expects no slip and both outputs low. Between these directed cases, random level sequences are checked every cycle against a model in the bench that is built from the requirements.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= lvl_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], lvl_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ref_rise_i,
  input  logic  fb_rise_i,
  output logic  up_o,
  output logic  dn_o,
  output logic  slip_o,
  output step_e step_o
);
  logic up_q, dn_q, slip_q;
  logic up_n, dn_n;

  always_comb begin
    up_n = up_q | ref_rise_i;
    dn_n = dn_q | fb_rise_i;
    if (up_n && dn_n) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      slip_q <= 1'b0;
    end else begin
      up_q   <= up_n;
      dn_q   <= dn_n;
      slip_q <= up_q & ref_rise_i & ~fb_rise_i;
    end
  end

  always_comb begin
    unique case ({up_q, dn_q})
      2'b10:   step_o = STEP_INC;
      2'b01:   step_o = STEP_DEC;
      default: step_o = STEP_HOLD;
    endcase
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign slip_o = slip_q;
endmodule

// File: rtl/pfd_err_integ.sv
module pfd_err_integ
  import pfd_pkg::*;
#(
  parameter int unsigned ERR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  step_e                   step_i,
  output logic signed [ERR_W-1:0] err_o
);
  localparam logic signed [ERR_W-1:0] MaxV = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] MinV = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] One  = {{(ERR_W-1){1'b0}}, 1'b1};

  logic signed [ERR_W-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (clr_i) begin
      err_q <= '0;
    end else begin
      unique case (step_i)
        STEP_INC: if (err_q != MaxV) err_q <= err_q + One;
        STEP_DEC: if (err_q != MinV) err_q <= err_q - One;
        default:  err_q <= err_q;
      endcase
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pfd_track.sv
module pfd_track
  import pfd_pkg::*;
#(
  parameter int unsigned ERR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ref_i,
  input  logic                    fb_i,
  input  logic                    clr_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    slip_o
);
  logic  ref_rise, fb_rise;
  step_e step;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ref_i),
    .rise_o(ref_rise)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (fb_i),
    .rise_o(fb_rise)
  );

  pfd_tristate u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(ref_rise),
    .fb_rise_i (fb_rise),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .slip_o    (slip_o),
    .step_o    (step)
  );

  pfd_err_integ #(.ERR_W(ERR_W)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .step_i(step),
    .err_o (err_o)
  );
endmodule

// File: rtl/pfd_track_chk.sv
module pfd_track_chk #(
  parameter int unsigned ERR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clr_i,
  input logic                    up_o,
  input logic                    dn_o,
  input logic signed [ERR_W-1:0] err_o,
  input logic                    slip_o
);
  localparam logic signed [ERR_W-1:0] MaxV = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] MinV = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] One  = {{(ERR_W-1){1'b0}}, 1'b1};

  a_r3_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  a_r6_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_o && !dn_o && err_o != MaxV) |=> (err_o == $past(err_o) + One));

  a_r6_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dn_o && !up_o && err_o != MinV) |=> (err_o == $past(err_o) - One));

  a_r7_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_o && !dn_o && err_o == MaxV) |=> (err_o == MaxV));

  a_r7_hold_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dn_o && !up_o && err_o == MinV) |=> (err_o == MinV));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_o == '0));

  a_r8_slip_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);

  a_r8_slip_keeps_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> up_o);

  always_comb begin
    if (!rst_ni) begin
      a_r10_reset: assert (!up_o && !dn_o && !slip_o && err_o == '0);
    end
  end
endmodule

bind pfd_track pfd_track_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (clr_i),
  .up_o  (up_o),
  .dn_o  (dn_o),
  .err_o (err_o),
  .slip_o(slip_o)
);

// File: tb/test_pfd_track.sv
`timescale 1ns/1ps
module test_pfd_track;
  localparam int ERR_W = 8;
  localparam int MAXV  = (1 << (ERR_W-1)) - 1;
  localparam int MINV  = -(1 << (ERR_W-1));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0, clr_i = 1'b0;
  logic up_o, dn_o, slip_o;
  logic signed [ERR_W-1:0] err_o;

  int checks = 0, errors = 0;
  int up_cnt = 0, dn_cnt = 0, slip_cnt = 0;
  bit done = 0;

  // reference model state
  logic r1, r2, rp, f1, f2, fp, m_up, m_dn, m_slip;
  int   m_err;

  always #2.5 clk_i = ~clk_i;

  pfd_track #(.ERR_W(ERR_W)) i_pfd_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i), .clr_i(clr_i),
    .up_o(up_o), .dn_o(dn_o), .err_o(err_o), .slip_o(slip_o)
  );

  function automatic int sat_step(int v, logic u, logic d, logic c);
    if (c) return 0;
    if (u && !d) return (v == MAXV) ? v : v + 1;
    if (d && !u) return (v == MINV) ? v : v - 1;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic r, logic f, logic c);
    logic rr, fr, un, dn;
    rr = r2 & ~rp;
    fr = f2 & ~fp;
    m_err = sat_step(m_err, m_up, m_dn, c);
    un = m_up | rr;
    dn = m_dn | fr;
    if (un && dn) begin un = 1'b0; dn = 1'b0; end
    m_slip = m_up & rr & ~fr;
    m_up = un;
    m_dn = dn;
    rp = r2; r2 = r1; r1 = r;
    fp = f2; f2 = f1; f1 = f;
  endtask

  task automatic tick(logic r, logic f, logic c);
    ref_i = r; fb_i = f; clr_i = c;
    @(posedge clk_i);
    model_edge(r, f, c);
    #1;
    check(up_o == m_up, "R1/R3 up", up_o, m_up);
    check(dn_o == m_dn, "R2/R3 dn", dn_o, m_dn);
    check(int'(err_o) == m_err, "R6 err", int'(err_o), m_err);
    check(slip_o == m_slip, "R8 slip", slip_o, m_slip);
    up_cnt += up_o; dn_cnt += dn_o; slip_cnt += slip_o;
    @(negedge clk_i);
  endtask

  task automatic clear_tallies();
    up_cnt = 0; dn_cnt = 0; slip_cnt = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    {r1, r2, rp, f1, f2, fp, m_up, m_dn, m_slip} = '0;
    m_err = 0;
    repeat (3) @(posedge clk_i);
    #1;
    check(!up_o && !dn_o && !slip_o && err_o == 0, "R10 reset", int'(err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 latency: up must appear on third edge
    tick(1, 0, 0); tick(1, 0, 0);
    check(up_o == 1'b0, "R1 early", up_o, 0);
    tick(1, 0, 0);
    check(up_o == 1'b1, "R1 latency", up_o, 1);
    tick(1, 1, 0); repeat (4) tick(1, 1, 0);
    repeat (4) tick(0, 0, 0);

    // R4 reference leads by 5 cycles
    tick(0, 0, 1); clear_tallies();
    repeat (5) tick(1, 0, 0);
    repeat (8) tick(1, 1, 0);
    repeat (6) tick(0, 0, 0);
    check(up_cnt == 5, "R4 up width", up_cnt, 5);
    check(dn_cnt == 0, "R4 no dn", dn_cnt, 0);
    check(int'(err_o) == 5, "R4/R6 err", int'(err_o), 5);

    // R4 mirror: feedback leads by 3
    tick(0, 0, 1); clear_tallies();
    repeat (3) tick(0, 1, 0);
    repeat (8) tick(1, 1, 0);
    repeat (6) tick(0, 0, 0);
    check(dn_cnt == 3, "R4 dn width", dn_cnt, 3);
    check(int'(err_o) == -3, "R4/R6 err neg", int'(err_o), -3);

    // R3 simultaneous edges
    clear_tallies();
    repeat (8) tick(1, 1, 0);
    repeat (6) tick(0, 0, 0);
    check(up_cnt == 0 && dn_cnt == 0, "R3 simultaneous", up_cnt + dn_cnt, 0);

    // R7 positive saturation, R11 held level, R8 slip
    tick(0, 0, 1); clear_tallies();
    repeat (300) tick(1, 0, 0);
    check(int'(err_o) == MAXV, "R7 max", int'(err_o), MAXV);
    check(up_o == 1'b1, "R11 held high", up_o, 1);
    repeat (4) tick(0, 0, 0);
    check(up_o == 1'b1, "R11 falling ignored", up_o, 1);
    repeat (6) tick(1, 0, 0);
    check(slip_cnt == 1, "R8 slip count", slip_cnt, 1);
    check(up_o == 1'b1, "R8 up kept", up_o, 1);
    // R8 slip suppressed when both edges coincide
    repeat (4) tick(0, 0, 0);
    clear_tallies();
    repeat (6) tick(1, 1, 0);
    check(slip_cnt == 0, "R8 coincide no slip", slip_cnt, 0);
    check(!up_o && !dn_o, "R3 coincide clears", up_o, 0);
    repeat (4) tick(0, 0, 0);

    // R7 negative saturation
    repeat (300) tick(0, 1, 0);
    check(int'(err_o) == MINV, "R7 min", int'(err_o), MINV);
    repeat (6) tick(1, 1, 0);
    repeat (4) tick(0, 0, 0);

    // R9 clear while stepping
    repeat (6) tick(1, 0, 0);
    check(up_o == 1'b1, "R9 setup up", up_o, 1);
    tick(1, 0, 1);
    check(int'(err_o) == 0, "R9 clear priority", int'(err_o), 0);
    repeat (6) tick(1, 1, 0);
    repeat (4) tick(0, 0, 0);

    // R5 reference faster than feedback
    tick(0, 0, 1);
    for (int c = 0; c < 600; c++) tick((c % 10) < 5, (c % 13) < 6, 0);
    check(int'(err_o) > 0, "R5 drift positive", int'(err_o), 1);
    tick(0, 0, 1);
    for (int c = 0; c < 600; c++) tick((c % 13) < 6, (c % 10) < 5, 0);
    check(int'(err_o) < 0, "R5 drift negative", int'(err_o), -1);

    // random levels
    for (int c = 0; c < 3000; c++) begin
      logic r, f;
      r = ($urandom % 4 == 0) ? ~ref_i : ref_i;
      f = ($urandom % 4 == 0) ? ~fb_i : fb_i;
      tick(r, f, ($urandom % 97) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule